// File: doc/BRIEF.md
# Track Format Byte Sequencer

This block produces the complete byte stream used to lay down a fresh soft-sectored track on a rotating disk. An encoder that sits downstream turns the stream into MFM flux transitions. Software loads the cylinder, head, sector count, gap lengths and a data fill byte, then pulses `start`. The sequencer arms and waits for the leading edge of the index pulse. From that edge it emits the pre-gap. For each sector it then emits an ID record and a data record. After the last sector it keeps emitting filler until index comes round again.

The encoder is fed one item at a time through a valid/ready pair. An item can be a plain byte. It can be an address-mark byte, which is flagged so the encoder can drop the missing clock bit. It can also be a CRC request, which tells the encoder to append its own two-byte CRC of the field it has just written. If index returns before the last sector's data CRC request has been accepted, the track is too long for the revolution, and the sequencer stops with an error flag.

Top module: `trk_fmt_seq`

## Requirements
- R1: After `start`, no item is offered until a rising edge of `index` is seen. That edge begins the track. A `start` is accepted only while idle.
- R2: The track opens with a run of 4E bytes. Its length is `gap1_len`, or 12 when `gap1_len` is below 12.
- R3: Each sector, numbered 0 to `nsec`-1, emits the following items in order:
  - 13 bytes of 00;
  - A1 as a mark;
  - FE;
  - `cyl[15:8]`, `cyl[7:0]`, `head` and the sector number;
  - a CRC request;
  - `gap2_len` bytes of 4E;
  - 13 bytes of 00;
  - A1 as a mark;
  - F8;
  - 256 bytes of `fill_byte`;
  - a CRC request;
  - `gap3_len` bytes of 4E.

  A gap length of 0 is treated as 1.
- R4: `mark` is raised only with byte A1. `crc_req` is raised with byte 00 and never together with `mark`.
- R5: After the last sector, 4E bytes are offered until the next rising edge of `index`. The block then raises `done` and stops offering items.
- R6: A rising edge of `index` before the last sector's data CRC request has been accepted raises `err`, leaves `done` low, and stops the stream.
- R7: Only the rising edge of `index` counts. An `index` that is already high at `start`, or that stays high, neither starts nor ends a track.
- R8: An item advances only in a cycle where `byte_valid` and `enc_ready` are both high. While `enc_ready` is low, the offered item and its flags hold steady.
- R9: After reset, `byte_valid`, `done` and `err` are low. An accepted `start` clears `done` and `err`.
- R10: With `nsec` equal to 0, the opening gap is followed directly by the end filler of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms the sequencer for one track |
| index | input | 1 | Once-per-revolution index pulse, active high |
| cyl | input | 16 | Cylinder number written into every ID record |
| head | input | 8 | Head number written into every ID record |
| nsec | input | 8 | Number of sectors on the track |
| gap1_len | input | 8 | Requested length of the opening gap |
| gap2_len | input | 8 | Gap length between an ID record and its data record |
| gap3_len | input | 8 | Gap length after each data record |
| fill_byte | input | 8 | Constant byte written into every data field |
| enc_ready | input | 1 | Encoder accepts the offered item |
| byte_out | output | 8 | Offered byte |
| byte_valid | output | 1 | An item is offered |
| mark | output | 1 | Offered byte is an address mark |
| crc_req | output | 1 | Offered item asks the encoder to append its CRC |
| done | output | 1 | Track completed at the closing index edge |
| err | output | 1 | Track overran the revolution |

## Verification
On every cycle, the assertions check the following:
- mark and CRC flags appear only with their proper bytes;
- a stalled item stays frozen;
- `done` and `err` never appear together;
- no item is offered once either flag is set;
- `done` rises only just after a rising index edge.

The item order, the ID contents, the gap-1 clamp, the error on a short revolution, the handling of a held-high index and the zero-sector track can only be shown by the bench. It runs whole tracks and compares every accepted item against an expected stream.

// File: rtl/trk_fmt_seq.sv
module trk_fmt_seq #(
  parameter int DATA_LEN = 256,
  parameter int SYNC_LEN = 13,
  parameter int GAP1_MIN = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        index,
  input  logic [15:0] cyl,
  input  logic [7:0]  head,
  input  logic [7:0]  nsec,
  input  logic [7:0]  gap1_len,
  input  logic [7:0]  gap2_len,
  input  logic [7:0]  gap3_len,
  input  logic [7:0]  fill_byte,
  input  logic        enc_ready,
  output logic [7:0]  byte_out,
  output logic        byte_valid,
  output logic        mark,
  output logic        crc_req,
  output logic        done,
  output logic        err
);
  localparam int CW = $clog2(DATA_LEN + 256);

  typedef enum logic [3:0] {
    S_IDLE, S_ARM, S_GAP1, S_SYNCI, S_AMI, S_IDT, S_ID, S_CRCI,
    S_GAP2, S_SYNCD, S_AMD, S_DT, S_DATA, S_CRCD, S_GAP3, S_GAP4
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, len;
  logic [7:0] sec, g1, g2, g3;
  logic idx_q;

  wire idx_edge  = index & ~idx_q;
  wire take      = byte_valid & enc_ready;
  wire last_byte = (cnt == len - 1'b1);
  wire last_sec  = (sec == nsec - 8'd1);
  wire tail_ok   = (st == S_GAP4) || (st == S_GAP3 && last_sec);

  assign g1 = (gap1_len < 8'(GAP1_MIN)) ? 8'(GAP1_MIN) : gap1_len;
  assign g2 = (gap2_len == 8'd0) ? 8'd1 : gap2_len;
  assign g3 = (gap3_len == 8'd0) ? 8'd1 : gap3_len;

  assign byte_valid = (st != S_IDLE) && (st != S_ARM);
  assign mark       = (st == S_AMI) || (st == S_AMD);
  assign crc_req    = (st == S_CRCI) || (st == S_CRCD);

  always_comb begin
    case (st)
      S_GAP1:          len = CW'(g1);
      S_SYNCI, S_SYNCD: len = CW'(SYNC_LEN);
      S_ID:            len = CW'(4);
      S_GAP2:          len = CW'(g2);
      S_DATA:          len = CW'(DATA_LEN);
      S_GAP3:          len = CW'(g3);
      default:         len = CW'(1);
    endcase
  end

  always_comb begin
    case (st)
      S_GAP1:  nxt = (nsec == 8'd0) ? S_GAP4 : S_SYNCI;
      S_SYNCI: nxt = S_AMI;
      S_AMI:   nxt = S_IDT;
      S_IDT:   nxt = S_ID;
      S_ID:    nxt = S_CRCI;
      S_CRCI:  nxt = S_GAP2;
      S_GAP2:  nxt = S_SYNCD;
      S_SYNCD: nxt = S_AMD;
      S_AMD:   nxt = S_DT;
      S_DT:    nxt = S_DATA;
      S_DATA:  nxt = S_CRCD;
      S_CRCD:  nxt = S_GAP3;
      S_GAP3:  nxt = last_sec ? S_GAP4 : S_SYNCI;
      default: nxt = st;
    endcase
  end

  always_comb begin
    case (st)
      S_AMI, S_AMD: byte_out = 8'hA1;
      S_IDT:        byte_out = 8'hFE;
      S_DT:         byte_out = 8'hF8;
      S_DATA:       byte_out = fill_byte;
      S_ID: begin
        case (cnt[1:0])
          2'd0:    byte_out = cyl[15:8];
          2'd1:    byte_out = cyl[7:0];
          2'd2:    byte_out = head;
          default: byte_out = sec;
        endcase
      end
      S_GAP1, S_GAP2, S_GAP3, S_GAP4: byte_out = 8'h4E;
      default:      byte_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sec   <= '0;
      idx_q <= 1'b1;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      idx_q <= index;
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0;
          err  <= 1'b0;
          st   <= S_ARM;
        end
        S_ARM: if (idx_edge) begin
          st  <= S_GAP1;
          cnt <= '0;
          sec <= '0;
        end
        default: begin
          if (idx_edge) begin
            st <= S_IDLE;
            if (tail_ok) done <= 1'b1;
            else         err  <= 1'b1;
          end else if (take) begin
            if (last_byte) begin
              cnt <= '0;
              st  <= nxt;
              if (st == S_GAP3 && !last_sec) sec <= sec + 8'd1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/trk_fmt_seq_chk.sv
module trk_fmt_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       index,
  input logic       enc_ready,
  input logic [7:0] byte_out,
  input logic       byte_valid,
  input logic       mark,
  input logic       crc_req,
  input logic       done,
  input logic       err
);
  AST_MARK_IS_A1: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> byte_valid && byte_out == 8'hA1); // R4
  AST_CRC_NOT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    crc_req |-> !mark && byte_out == 8'h00); // R4
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !enc_ready && !(index && !$past(index)))
      |=> byte_valid && $stable(byte_out) && $stable(mark) && $stable(crc_req)); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R6
  AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !byte_valid); // R5
  AST_DONE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(index) && !$past(index, 2)); // R7
endmodule

bind trk_fmt_seq trk_fmt_seq_chk chk_i (.*);

// File: tb/trk_fmt_seq_tb_top.sv
module trk_fmt_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, index = 1'b0, enc_ready = 1'b1;
  logic [15:0] cyl = 16'h1234;
  logic [7:0] head = 8'h03, nsec = 8'd2, gap1_len = 8'd16, gap2_len = 8'd5;
  logic [7:0] gap3_len = 8'd6, fill_byte = 8'hE5;
  logic [7:0] byte_out;
  logic byte_valid, mark, crc_req, done, err;

  int checks = 0, errors = 0, cyc = 0, ph = 0, stall_mode = 0;
  int rec_n = 0, exp_n = 0;
  logic [7:0] rec_b [0:8191];
  logic       rec_m [0:8191];
  logic       rec_c [0:8191];
  logic [7:0] exp_b [0:2047];
  logic       exp_m [0:2047];
  logic       exp_c [0:2047];

  trk_fmt_seq dut_i (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    ph++;
    enc_ready = (stall_mode != 0) ? (ph % 3 != 2) : 1'b1;
    if (byte_valid && enc_ready && rec_n < 8192) begin
      rec_b[rec_n] = byte_out;
      rec_m[rec_n] = mark;
      rec_c[rec_n] = crc_req;
      rec_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic m, input logic c);
    exp_b[exp_n] = b; exp_m[exp_n] = m; exp_c[exp_n] = c; exp_n++;
  endtask

  task automatic build_exp();
    int g1 = (gap1_len < 12) ? 12 : int'(gap1_len);
    int g2 = (gap2_len == 0) ? 1 : int'(gap2_len);
    int g3 = (gap3_len == 0) ? 1 : int'(gap3_len);
    exp_n = 0;
    for (int i = 0; i < g1; i++) push(8'h4E, 0, 0);
    for (int s = 0; s < int'(nsec); s++) begin
      for (int i = 0; i < 13; i++) push(8'h00, 0, 0);
      push(8'hA1, 1, 0); push(8'hFE, 0, 0);
      push(cyl[15:8], 0, 0); push(cyl[7:0], 0, 0); push(head, 0, 0); push(8'(s), 0, 0);
      push(8'h00, 0, 1);
      for (int i = 0; i < g2; i++) push(8'h4E, 0, 0);
      for (int i = 0; i < 13; i++) push(8'h00, 0, 0);
      push(8'hA1, 1, 0); push(8'hF8, 0, 0);
      for (int i = 0; i < 256; i++) push(fill_byte, 0, 0);
      push(8'h00, 0, 1);
      for (int i = 0; i < g3; i++) push(8'h4E, 0, 0);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_index();
    @(negedge clk) index = 1'b1;
    repeat (4) @(negedge clk);
    index = 1'b0;
  endtask

  task automatic wait_items(input int n);
    while (rec_n < n) @(negedge clk);
  endtask

  task automatic compare(input int b0, input string req);
    int bad = -1;
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && (rec_b[b0+i] !== exp_b[i] || rec_m[b0+i] !== exp_m[i] || rec_c[b0+i] !== exp_c[i]))
        bad = i;
    if (bad >= 0)
      chk(0, req, $sformatf("stream item %0d", bad), {rec_m[b0+bad], rec_c[b0+bad], rec_b[b0+bad]},
          {exp_m[bad], exp_c[bad], exp_b[bad]});
    else chk(1, req, "stream", 0, 0);
  endtask

  task automatic finish_track(input int b0);
    int bad = 0;
    wait_items(b0 + exp_n + 20);
    pulse_index();
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R5", "done after closing index", done, 1);
    chk(err === 1'b0, "R5", "err after closing index", err, 0);
    chk(byte_valid === 1'b0, "R5", "valid after done", byte_valid, 0);
    for (int i = b0 + exp_n; i < rec_n; i++)
      if (rec_b[i] !== 8'h4E || rec_m[i] || rec_c[i]) bad++;
    chk(bad == 0 && rec_n >= b0 + exp_n + 20, "R5", "end filler bad items", bad, 0);
  endtask

  task automatic t_reset();
    chk(byte_valid === 1'b0, "R9", "valid after reset", byte_valid, 0);
    chk(done === 1'b0 && err === 1'b0, "R9", "flags after reset", {done, err}, 0);
  endtask

  task automatic t_basic();
    int b0 = rec_n;
    nsec = 2; gap1_len = 16; gap2_len = 5; gap3_len = 6; stall_mode = 0;
    build_exp();
    pulse_start();
    repeat (20) @(negedge clk);
    chk(rec_n == b0, "R1", "items before index", rec_n - b0, 0);
    pulse_index();
    wait_items(b0 + exp_n);
    compare(b0, "R3");
    finish_track(b0);
  endtask

  task automatic t_gap1_clamp();
    int b0 = rec_n, run = 0;
    nsec = 1; gap1_len = 5; gap2_len = 0; gap3_len = 3; stall_mode = 0;
    build_exp();
    pulse_start();
    chk(done === 1'b0, "R9", "start clears done", done, 0);
    pulse_index();
    wait_items(b0 + exp_n);
    while (rec_b[b0+run] === 8'h4E) run++;
    chk(run == 12, "R2", "opening gap length", run, 12);
    compare(b0, "R2");
    finish_track(b0);
  endtask

  task automatic t_stall();
    int b0 = rec_n;
    nsec = 2; gap1_len = 14; gap2_len = 3; gap3_len = 4; stall_mode = 1;
    build_exp();
    pulse_start();
    pulse_index();
    wait_items(b0 + exp_n);
    compare(b0, "R8");
    finish_track(b0);
    stall_mode = 0;
  endtask

  task automatic t_early();
    int b0 = rec_n;
    nsec = 3; gap1_len = 16; gap2_len = 5; gap3_len = 5;
    pulse_start();
    pulse_index();
    wait_items(b0 + 400);
    pulse_index();
    repeat (2) @(negedge clk);
    chk(err === 1'b1, "R6", "err on early index", err, 1);
    chk(done === 1'b0, "R6", "done on early index", done, 0);
    chk(byte_valid === 1'b0, "R6", "valid after abort", byte_valid, 0);
    pulse_start();
    @(negedge clk);
    chk(err === 1'b0, "R9", "start clears err", err, 0);
    index = 1'b1; repeat (2) @(negedge clk); index = 1'b0;
    repeat (2) @(negedge clk);
    pulse_index();
    repeat (2) @(negedge clk);
    chk(err === 1'b1, "R6", "err again in opening gap", err, 1);
  endtask

  task automatic t_level();
    int b0 = rec_n;
    nsec = 1; gap1_len = 12; gap2_len = 2; gap3_len = 2;
    build_exp();
    @(negedge clk) index = 1'b1;
    pulse_start();
    repeat (30) @(negedge clk);
    chk(rec_n == b0, "R7", "items with index held high", rec_n - b0, 0);
    index = 1'b0;
    pulse_index();
    wait_items(b0 + exp_n + 10);
    compare(b0, "R7");
    @(negedge clk) index = 1'b1;
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R7", "done after rising edge", done, 1);
    index = 1'b0;
  endtask

  task automatic t_zero();
    int b0 = rec_n;
    nsec = 0; gap1_len = 13;
    build_exp();
    pulse_start();
    pulse_index();
    wait_items(b0 + exp_n);
    compare(b0, "R10");
    finish_track(b0);
  endtask

  initial begin
    while (cyc < 150000) begin @(negedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gap1_clamp();
    t_stall();
    t_early();
    t_level();
    t_zero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule